// File: doc/BRIEF.md
# DSP Subsystem Power-Up Sequencer

This block walks a DSP subsystem from its powered-down, clamped condition to a running core. Each step of the walk is one register write, held in its own state. Three control registers are driven: a reset control word, a power control word and a single clock-enable bit. One write is made per clock, except for a programmable settle interval that follows the power-switch write. The outputs are the live register contents, so the power and reset logic of the subsystem can be driven from them directly.

After the core is let go, the sequencer watches the status word written by the core's boot ROM. A value of one ends the run with success. Any other nonzero value, or no value at all within the timeout window, ends the run with an error code. The run is started by a single pulse on the start input. Once a run has finished, only a reset brings the block back to idle.

Top module: `dsp_pwrup_seq`

## Requirements
- R1: While reset is held, and after it is released, reset control reads 0, power control holds only bit 20 (IO clamp), the clock enable is 0, done is 0 and the error code is 0.
- R2: One cycle after start is sampled high in idle, reset control bits 0 (core stop), 1 (core reset) and 2 (bus reset enable) all become 1 in the same write.
- R3: On the next cycle, power control bits 21 (head switch) and 22 (regulator bypass) are set together. The next write then follows exactly SETTLE_CYC+1 cycles later.
- R4: That next write sets power control bits 16, 17, 18 and 19 together.
- R5: The memory bank enables are then set in separate writes on consecutive cycles: power bit 2 first, then bit 1, then bit 0.
- R6: On the four cycles after that, in this order: power bit 20 is cleared, reset bit 1 is cleared, the clock enable is set, and reset bit 0 is cleared. Reset control ends at 4.
- R7: A boot status of exactly 1 seen while waiting sets done one cycle later, with error code 0.
- R8: Any other nonzero boot status seen while waiting sets done one cycle later, with error code 2.
- R9: If the status stays zero for TIMEOUT_CYC cycles after core stop clears, done rises in the following cycle with error code 1. A status that arrives in the last cycle of the window still counts as an answer.
- R10: Start pulses during a run, or after a run has finished, have no effect: the write order, the spacing and the final outputs are unchanged.
- R11: A nonzero boot status present before core stop clears neither shortens the sequence nor ends it. Done stays 0 until the wait has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when sampled high in idle |
| boot_status_i | input | STAT_W | Status word from the boot ROM |
| rst_ctl_o | output | 3 | Reset control word |
| pwr_ctl_o | output | 23 | Power control word |
| clk_en_o | output | 1 | Core clock enable |
| done_o | output | 1 | Run finished |
| err_o | output | 2 | 0 ok, 1 timeout, 2 unexpected status |

## Verification
The boot-status check and the timeout expiry can resolve in the same cycle. This happens when the status first turns nonzero on the last cycle of the wait window. The bench counts cycles from the clock edge at which core stop clears, holds the status at zero for TIMEOUT_CYC-1 cycles, and then presents the value 1 just before the edge at which the timeout would fire. The run is judged correct only if done rises on that edge with error code 0. A separate run with the status held at zero must instead produce error code 1 on that same edge.

// File: rtl/dsp_pwrup_pkg.sv
package dsp_pwrup_pkg;
  localparam int RST_W   = 3;
  localparam int PWR_W   = 23;
  localparam int N_BANKS = 3;

  // reset control bits
  localparam int RB_STOP = 0;
  localparam int RB_ARES = 1;
  localparam int RB_BUS  = 2;

  // power control bits; banks occupy [N_BANKS-1:0]
  localparam int PB_TAG   = 16;
  localparam int PB_ETB   = 17;
  localparam int PB_STBY  = 18;
  localparam int PB_SLPRT = 19;
  localparam int PB_CLAMP = 20;
  localparam int PB_HEAD  = 21;
  localparam int PB_LDOBY = 22;

  localparam logic [PWR_W-1:0] PWR_RST   = PWR_W'(1) << PB_CLAMP;
  localparam logic [PWR_W-1:0] HEAD_MASK = (PWR_W'(1) << PB_HEAD) | (PWR_W'(1) << PB_LDOBY);
  localparam logic [PWR_W-1:0] MEM_MASK  = (PWR_W'(1) << PB_TAG) | (PWR_W'(1) << PB_ETB) |
                                           (PWR_W'(1) << PB_STBY) | (PWR_W'(1) << PB_SLPRT);

  typedef enum logic [3:0] {
    ST_IDLE, ST_HEAD, ST_SETTLE, ST_MEM, ST_BANK, ST_UNCLAMP,
    ST_DEASSERT, ST_CLKON, ST_RELEASE, ST_WAIT, ST_OK, ST_FAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_STATUS  = 2'd2
  } seq_err_e;
endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int CNT_MAX = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic zero_o
);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(CNT_MAX - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= LOAD_V;
    else if (en_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3
  load_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == LOAD_V));
endmodule

// File: rtl/pwrup_ctrl.sv
module pwrup_ctrl
  import dsp_pwrup_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STAT_W-1:0] boot_status_i,
  input  logic              settle_zero_i,
  input  logic              tmo_zero_i,
  output logic              settle_load_o,
  output logic              settle_en_o,
  output logic              tmo_load_o,
  output logic              tmo_en_o,
  output logic [RST_W-1:0]  rst_ctl_o,
  output logic [PWR_W-1:0]  pwr_ctl_o,
  output logic              clk_en_o,
  output logic              done_o,
  output logic [1:0]        err_o
);
  localparam int BI_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;

  seq_state_e       state_q;
  seq_err_e         err_q;
  logic [BI_W-1:0]  bank_q;
  logic [RST_W-1:0] rst_q;
  logic [PWR_W-1:0] pwr_q;
  logic             clk_q, done_q;
  logic             stat_seen, stat_good;

  assign stat_seen = (boot_status_i != '0);
  assign stat_good = (boot_status_i == STAT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= ERR_NONE;
      bank_q  <= '0;
      rst_q   <= '0;
      pwr_q   <= PWR_RST;
      clk_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          rst_q   <= rst_q | RST_W'((1 << RB_STOP) | (1 << RB_ARES) | (1 << RB_BUS));
          state_q <= ST_HEAD;
        end
        ST_HEAD: begin
          pwr_q   <= pwr_q | HEAD_MASK;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_zero_i) state_q <= ST_MEM;
        ST_MEM: begin
          pwr_q   <= pwr_q | MEM_MASK;
          bank_q  <= BI_W'(N_BANKS - 1);
          state_q <= ST_BANK;
        end
        ST_BANK: begin
          // highest bank first, one per write
          pwr_q[bank_q] <= 1'b1;
          if (bank_q == '0) state_q <= ST_UNCLAMP;
          else              bank_q  <= bank_q - 1'b1;
        end
        ST_UNCLAMP: begin
          pwr_q[PB_CLAMP] <= 1'b0;
          state_q         <= ST_DEASSERT;
        end
        ST_DEASSERT: begin
          rst_q[RB_ARES] <= 1'b0;
          state_q        <= ST_CLKON;
        end
        ST_CLKON: begin
          clk_q   <= 1'b1;
          state_q <= ST_RELEASE;
        end
        ST_RELEASE: begin
          rst_q[RB_STOP] <= 1'b0;
          state_q        <= ST_WAIT;
        end
        ST_WAIT: begin
          // a status arriving on the last window cycle wins over the timeout
          if (stat_seen) begin
            done_q  <= 1'b1;
            err_q   <= stat_good ? ERR_NONE : ERR_STATUS;
            state_q <= stat_good ? ST_OK : ST_FAIL;
          end else if (tmo_zero_i) begin
            done_q  <= 1'b1;
            err_q   <= ERR_TIMEOUT;
            state_q <= ST_FAIL;
          end
        end
        ST_OK, ST_FAIL: ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign settle_load_o = (state_q == ST_HEAD);
  assign settle_en_o   = (state_q == ST_SETTLE);
  assign tmo_load_o    = (state_q == ST_RELEASE);
  assign tmo_en_o      = (state_q == ST_WAIT);
  assign rst_ctl_o     = rst_q;
  assign pwr_ctl_o     = pwr_q;
  assign clk_en_o      = clk_q;
  assign done_o        = done_q;
  assign err_o         = err_q;

  // R2
  one_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!$stable(rst_q), !$stable(pwr_q), !$stable(clk_q)}));

  // R3
  settle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_q[PB_TAG]) |-> $past(settle_zero_i));

  // R5
  for (genvar b = 0; b < N_BANKS - 1; b++) begin : g_bank_chk
    bank_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwr_q[b]) |-> pwr_q[b+1]);
  end

  // R6
  clamp_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_q[PB_CLAMP]) |-> (&pwr_q[N_BANKS-1:0]) && ((pwr_q & MEM_MASK) == MEM_MASK));

  // R6
  clk_after_ares_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q) |-> !rst_q[RB_ARES] && !pwr_q[PB_CLAMP]);

  // R7
  ok_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_q) && err_q == ERR_NONE) |-> $past(stat_good));

  // R9
  err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != ERR_NONE) |-> done_q);

  // R10
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q && $stable(rst_q) && $stable(pwr_q) && $stable(clk_q));
endmodule

// File: rtl/dsp_pwrup_seq.sv
module dsp_pwrup_seq
  import dsp_pwrup_pkg::*;
#(
  parameter int SETTLE_CYC  = 200,
  parameter int TIMEOUT_CYC = 200_000_000,
  parameter int STAT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STAT_W-1:0] boot_status_i,
  output logic [RST_W-1:0]  rst_ctl_o,
  output logic [PWR_W-1:0]  pwr_ctl_o,
  output logic              clk_en_o,
  output logic              done_o,
  output logic [1:0]        err_o
);
  logic settle_load, settle_en, settle_zero;
  logic tmo_load, tmo_en, tmo_zero;

  pwrup_timer #(.CNT_MAX(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (settle_load),
    .en_i   (settle_en),
    .zero_o (settle_zero)
  );

  pwrup_timer #(.CNT_MAX(TIMEOUT_CYC)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmo_load),
    .en_i   (tmo_en),
    .zero_o (tmo_zero)
  );

  pwrup_ctrl #(.STAT_W(STAT_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .boot_status_i (boot_status_i),
    .settle_zero_i (settle_zero),
    .tmo_zero_i    (tmo_zero),
    .settle_load_o (settle_load),
    .settle_en_o   (settle_en),
    .tmo_load_o    (tmo_load),
    .tmo_en_o      (tmo_en),
    .rst_ctl_o     (rst_ctl_o),
    .pwr_ctl_o     (pwr_ctl_o),
    .clk_en_o      (clk_en_o),
    .done_o        (done_o),
    .err_o         (err_o)
  );
endmodule

// File: tb/dsp_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module dsp_pwrup_seq_tb_top;
  localparam int SETTLE = 5;
  localparam int TMO    = 40;

  logic        clk = 1'b0;
  logic        rst_ni, start_i;
  logic [31:0] boot_status_i;
  logic [2:0]  rst_ctl_o;
  logic [22:0] pwr_ctl_o;
  logic        clk_en_o, done_o;
  logic [1:0]  err_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [26:0] exp_s [10];
  int          exp_g [10];
  string       exp_r [10];

  always #2.5 clk = ~clk;

  dsp_pwrup_seq #(.SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO), .STAT_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .boot_status_i(boot_status_i),
    .rst_ctl_o(rst_ctl_o), .pwr_ctl_o(pwr_ctl_o), .clk_en_o(clk_en_o),
    .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [26:0] snap();
    return {rst_ctl_o, pwr_ctl_o, clk_en_o};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic init_exp();
    logic [22:0] c, p;
    c = 23'h1 << 20;
    p = c;
    exp_s[0] = {3'b111, p, 1'b0};                      exp_g[0] = 1;          exp_r[0] = "R2";
    p = p | (23'h1 << 21) | (23'h1 << 22);
    exp_s[1] = {3'b111, p, 1'b0};                      exp_g[1] = 1;          exp_r[1] = "R3";
    p = p | (23'hF << 16);
    exp_s[2] = {3'b111, p, 1'b0};                      exp_g[2] = SETTLE + 1; exp_r[2] = "R4";
    p = p | 23'h4; exp_s[3] = {3'b111, p, 1'b0};       exp_g[3] = 1;          exp_r[3] = "R5";
    p = p | 23'h2; exp_s[4] = {3'b111, p, 1'b0};       exp_g[4] = 1;          exp_r[4] = "R5";
    p = p | 23'h1; exp_s[5] = {3'b111, p, 1'b0};       exp_g[5] = 1;          exp_r[5] = "R5";
    p = p & ~c;    exp_s[6] = {3'b111, p, 1'b0};       exp_g[6] = 1;          exp_r[6] = "R6";
    exp_s[7] = {3'b101, p, 1'b0};                      exp_g[7] = 1;          exp_r[7] = "R6";
    exp_s[8] = {3'b101, p, 1'b1};                      exp_g[8] = 1;          exp_r[8] = "R6";
    exp_s[9] = {3'b100, p, 1'b1};                      exp_g[9] = 1;          exp_r[9] = "R6";
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; start_i = 1'b0; boot_status_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // pulses start, then follows the ten writes; poke re-pulses start on that cycle
  task automatic run_seq(input int poke);
    logic [26:0] prev, cur;
    int k = 0;
    int last = 0;
    prev = snap();
    start_i = 1'b1;
    for (int c = 1; c <= 500 && k < 10; c++) begin
      @(negedge clk);
      start_i = (c == poke);
      cur = snap();
      if (cur != prev) begin
        chk(exp_r[k], $sformatf("write %0d value", k), 32'(cur), 32'(exp_s[k]));
        chk((k == 2) ? "R3" : exp_r[k], $sformatf("write %0d spacing", k), 32'(c - last), 32'(exp_g[k]));
        chk("R11", "done low during bring-up", 32'(done_o), 32'd0);
        if (poke > 0) chk("R10", $sformatf("write %0d with extra start", k), 32'(cur), 32'(exp_s[k]));
        last = c; prev = cur; k++;
      end
    end
    start_i = 1'b0;
    chk("R2", "all writes seen", 32'(k), 32'd10);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; start_i = 1'b0; boot_status_i = '0;
    repeat (2) @(negedge clk);
    chk("R1", "rst_ctl in reset", 32'(rst_ctl_o), 32'd0);
    chk("R1", "pwr_ctl in reset", 32'(pwr_ctl_o), 32'h0010_0000);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "rst_ctl idle", 32'(rst_ctl_o), 32'd0);
    chk("R1", "pwr_ctl idle", 32'(pwr_ctl_o), 32'h0010_0000);
    chk("R1", "clk_en idle", 32'(clk_en_o), 32'd0);
    chk("R1", "done idle", 32'(done_o), 32'd0);
    chk("R1", "err idle", 32'(err_o), 32'd0);
  endtask

  task automatic t_success();
    do_reset();
    run_seq(-1);
    boot_status_i = 32'd1;
    @(negedge clk);
    chk("R7", "done after good status", 32'(done_o), 32'd1);
    chk("R7", "err after good status", 32'(err_o), 32'd0);
    boot_status_i = '0;
  endtask

  task automatic t_bad_status();
    do_reset();
    boot_status_i = 32'h0000_0003;
    run_seq(-1);
    chk("R11", "done low as core stop clears", 32'(done_o), 32'd0);
    @(negedge clk);
    chk("R8", "done after bad status", 32'(done_o), 32'd1);
    chk("R8", "err after bad status", 32'(err_o), 32'd2);
    boot_status_i = '0;
  endtask

  task automatic t_timeout();
    do_reset();
    run_seq(-1);
    repeat (TMO - 1) @(negedge clk);
    chk("R9", "done before window end", 32'(done_o), 32'd0);
    @(negedge clk);
    chk("R9", "done at timeout", 32'(done_o), 32'd1);
    chk("R9", "err at timeout", 32'(err_o), 32'd1);
  endtask

  task automatic t_last_cycle();
    do_reset();
    run_seq(-1);
    repeat (TMO - 1) @(negedge clk);
    boot_status_i = 32'd1;
    chk("R9", "done before last window cycle", 32'(done_o), 32'd0);
    @(negedge clk);
    chk("R9", "done on last-cycle status", 32'(done_o), 32'd1);
    chk("R9", "status wins over timeout", 32'(err_o), 32'd0);
    boot_status_i = '0;
  endtask

  task automatic t_start_ignored();
    logic [26:0] fin;
    do_reset();
    run_seq(3);
    boot_status_i = 32'd1;
    @(negedge clk);
    chk("R10", "done after restart pulse", 32'(done_o), 32'd1);
    fin = snap();
    boot_status_i = '0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10", "outputs after late start", 32'(snap()), 32'(fin));
    chk("R10", "done held", 32'(done_o), 32'd1);
    chk("R10", "err held", 32'(err_o), 32'd0);
  endtask

  initial begin
    init_exp();
    t_reset();
    t_success();
    t_bad_status();
    t_timeout();
    t_last_cycle();
    t_start_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule